// File: doc/BRIEF.md
# Streaming Write Allocation Detector

This block sits beside a cache write path and watches every write request: its byte address, its size in bytes and the block address it falls in. It remembers where the previous write ended. When a new write starts exactly there, the write continues a stream and its size is added to a running count of contiguous bytes. As that count grows past two configured limits, the block steps from a mode where writes allocate lines, to a mode where writes still allocate but are also coalesced, and finally to a mode where writes no longer allocate at all. Any write that breaks the stream sends the block back to the allocating mode, with the count restarted at that write's size.

A second part holds a small table of short countdown counters, one per table slot, with the slot chosen by the low bits of the block address. A write that continues the stream loads its slot with a configured hold value. A write that breaks the stream clears its slot. The cache controller queries a block before it releases a held write. The answer is "keep holding" while the slot is non-zero, and every query takes one off the slot. This lets the following sequential writes merge with the held one.

A clear input wipes all history: the mode, the count, the remembered end address and the table.

Top module: `stream_write_detector`

## Requirements
- R1: After reset or a clear, `alloc_o`=1, `coalesce_o`=0, every delay query answers 0, and the first write that follows counts as non-sequential.
- R2: Modes decode onto the outputs as follows: allocate gives `alloc_o`=1 and `coalesce_o`=0; coalesce gives 1 and 1; no-allocate gives 0 and 1. A write accepted at a clock edge is reflected on the outputs straight after that edge.
- R3: A write is sequential only when a previous write has been recorded since the last reset or clear, and its address equals the previous write's address plus its size, modulo 2^ADDR_W.
- R4: A sequential write in allocate or coalesce mode adds its size to the contiguous byte count. Allocate mode moves to coalesce mode when the new count is strictly greater than COALESCE_LIMIT.
- R5: Coalesce mode moves to no-allocate mode when the new count is strictly greater than NOALLOC_LIMIT. A single write advances the mode by at most one step.
- R6: A non-sequential write sets the count to its own size and puts the block in allocate mode, whatever the previous mode and whatever that size is.
- R7: Sequential writes in no-allocate mode leave the mode unchanged.
- R8: A sequential write loads table slot (wr_blk mod DELAY_ENTRIES) with DELAY_THRESH. A non-sequential write sets that slot to 0. Block addresses that share low bits share a slot.
- R9: A query presented on one edge drives `q_delay` after that edge: it is 1 when the queried slot was non-zero and 0 otherwise. A query also lowers a non-zero slot by one, and a slot at 0 stays at 0. With no query, `q_delay` is 0.
- R10: When a write and a query hit the same slot in the same cycle, the query answers from the slot's old value, and the slot takes the value the write gives it.
- R11: A clear takes priority over a write or a query in the same cycle; that write is not recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous request to drop all recorded history |
| wr_valid | input | 1 | A write request is present this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_size | input | SIZE_W | Size of the write in bytes |
| wr_blk | input | BLK_W | Block address of the write |
| q_valid | input | 1 | A delay query is present this cycle |
| q_blk | input | BLK_W | Block address being queried |
| q_delay | output | 1 | Registered query answer: keep holding the block's write |
| alloc_o | output | 1 | Writes should allocate cache lines |
| coalesce_o | output | 1 | Writes should be coalesced |

## Verification
Unbroken sequential streams are swept over several write sizes, so that the count reaches each limit on a different write; this separates strict from non-strict comparisons and shows that the count accumulates sizes rather than write events. Streams are broken from every mode, including a large first write that lands exactly on a limit, which shows that a restart never skips straight to a later mode. A stream that crosses the top of the address space checks the modular end-address compare. Delay slots are drained query by query, aliased through shared low block bits, and hit by a write and a query in the same cycle, and a clear collides with a write to show that it has priority.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [1:0] {
    WM_ALLOC   = 2'd0,
    WM_COAL    = 2'd1,
    WM_NOALLOC = 2'd2
  } wmode_t;
endpackage

// File: rtl/swd_seq_track.sv
module swd_seq_track #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  output logic              seq
);
  logic [ADDR_W-1:0] next_addr;
  logic              have_hist;
  logic [ADDR_W-1:0] end_addr;

  assign end_addr = wr_addr + ADDR_W'(wr_size);
  assign seq      = have_hist && (wr_addr == next_addr);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      next_addr <= '0;
      have_hist <= 1'b0;
    end else if (wr_valid) begin
      next_addr <= end_addr;
      have_hist <= 1'b1;
    end
  end
endmodule

// File: rtl/swd_mode_fsm.sv
module swd_mode_fsm
  import swd_pkg::*;
#(
  parameter int SIZE_W          = 7,
  parameter int COALESCE_LIMIT  = 128,
  parameter int NOALLOC_LIMIT   = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic              seq,
  input  logic [SIZE_W-1:0] wr_size,
  output wmode_t            mode
);
  localparam int MAX_SIZE = (1 << SIZE_W) - 1;
  localparam int CNT_W    = $clog2(NOALLOC_LIMIT + 2 * MAX_SIZE + 2) + 1;
  localparam logic [CNT_W-1:0] COAL_LIM_V = CNT_W'(COALESCE_LIMIT);
  localparam logic [CNT_W-1:0] NOAL_LIM_V = CNT_W'(NOALLOC_LIMIT);

  logic [CNT_W-1:0] byte_cnt;
  logic [CNT_W-1:0] cnt_sum;
  logic [CNT_W-1:0] cnt_nxt;
  wmode_t           mode_nxt;

  assign cnt_sum = byte_cnt + CNT_W'(wr_size);

  always_comb begin
    cnt_nxt  = byte_cnt;
    mode_nxt = mode;
    if (wr_valid) begin
      if (!seq) begin
        cnt_nxt  = CNT_W'(wr_size);
        mode_nxt = WM_ALLOC;
      end else if (mode != WM_NOALLOC) begin
        cnt_nxt = cnt_sum;
        if (mode == WM_ALLOC && cnt_sum > COAL_LIM_V) begin
          mode_nxt = WM_COAL;
        end else if (mode == WM_COAL && cnt_sum > NOAL_LIM_V) begin
          mode_nxt = WM_NOALLOC;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      byte_cnt <= '0;
      mode     <= WM_ALLOC;
    end else begin
      byte_cnt <= cnt_nxt;
      mode     <= mode_nxt;
    end
  end
endmodule

// File: rtl/swd_delay_table.sv
module swd_delay_table #(
  parameter int BLK_W         = 26,
  parameter int DELAY_ENTRIES = 16,
  parameter int DELAY_W       = 4,
  parameter int DELAY_THRESH  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_valid,
  input  logic             seq,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic             q_valid,
  input  logic [BLK_W-1:0] q_blk,
  output logic             q_delay
);
  localparam int IDX_W = (DELAY_ENTRIES > 1) ? $clog2(DELAY_ENTRIES) : 1;
  localparam logic [DELAY_W-1:0] THRESH_V = DELAY_W'(DELAY_THRESH);

  logic [IDX_W-1:0]   w_idx;
  logic [IDX_W-1:0]   r_idx;
  logic [DELAY_W-1:0] slot [DELAY_ENTRIES];
  logic               r_nonzero;

  assign w_idx     = IDX_W'(wr_blk % DELAY_ENTRIES);
  assign r_idx     = IDX_W'(q_blk % DELAY_ENTRIES);
  assign r_nonzero = (slot[r_idx] != '0);

  for (genvar g = 0; g < DELAY_ENTRIES; g++) begin : g_slot
    logic [DELAY_W-1:0] ctr;
    logic               hit_w;
    logic               hit_q;
    assign hit_w = wr_valid && (w_idx == IDX_W'(g));
    assign hit_q = q_valid && (r_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        ctr <= '0;
      end else if (hit_w) begin
        ctr <= seq ? THRESH_V : '0;
      end else if (hit_q && ctr != '0) begin
        ctr <= ctr - 1'b1;
      end
    end
    assign slot[g] = ctr;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q_delay <= 1'b0;
    end else begin
      q_delay <= q_valid && r_nonzero;
    end
  end
endmodule

// File: rtl/stream_write_detector.sv
module stream_write_detector
  import swd_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int SIZE_W         = 7,
  parameter int BLK_W          = 26,
  parameter int COALESCE_LIMIT = 128,
  parameter int NOALLOC_LIMIT  = 512,
  parameter int DELAY_ENTRIES  = 16,
  parameter int DELAY_W        = 4,
  parameter int DELAY_THRESH   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic              q_valid,
  input  logic [BLK_W-1:0]  q_blk,
  output logic              q_delay,
  output logic              alloc_o,
  output logic              coalesce_o
);
  logic   seq;
  wmode_t mode;

  swd_seq_track #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_track (
    .clk(clk), .rst(rst), .clr(clr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_size(wr_size), .seq(seq)
  );

  swd_mode_fsm #(
    .SIZE_W(SIZE_W), .COALESCE_LIMIT(COALESCE_LIMIT), .NOALLOC_LIMIT(NOALLOC_LIMIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .clr(clr), .wr_valid(wr_valid),
    .seq(seq), .wr_size(wr_size), .mode(mode)
  );

  swd_delay_table #(
    .BLK_W(BLK_W), .DELAY_ENTRIES(DELAY_ENTRIES),
    .DELAY_W(DELAY_W), .DELAY_THRESH(DELAY_THRESH)
  ) u_delay (
    .clk(clk), .rst(rst), .clr(clr), .wr_valid(wr_valid), .seq(seq),
    .wr_blk(wr_blk), .q_valid(q_valid), .q_blk(q_blk), .q_delay(q_delay)
  );

  assign alloc_o    = (mode != WM_NOALLOC);
  assign coalesce_o = (mode != WM_ALLOC);
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [SIZE_W-1:0] wr_size,
  input logic              q_valid,
  input logic              q_delay,
  input logic              alloc_o,
  input logic              coalesce_o
);
  logic [ADDR_W-1:0] sh_next;
  logic              sh_vld;
  logic              sh_seq;
  logic              started;

  assign sh_seq = sh_vld && (wr_addr == sh_next);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_next <= '0;
      sh_vld  <= 1'b0;
    end else if (wr_valid) begin
      sh_next <= wr_addr + ADDR_W'(wr_size);
      sh_vld  <= 1'b1;
    end
    if (rst) started <= 1'b1;
  end

  // R2: no encoding drives both outputs low
  a_r2_valid_code: assert property (@(posedge clk) disable iff (rst || !started)
    (alloc_o || coalesce_o));

  // R1 / R11: a clear always lands in allocate mode
  a_r1_clear_alloc: assert property (@(posedge clk) disable iff (rst || !started)
    clr |=> (alloc_o && !coalesce_o));

  // R6: a stream break returns to allocate mode
  a_r6_break_alloc: assert property (@(posedge clk) disable iff (rst || !started)
    (!clr && wr_valid && !sh_seq) |=> (alloc_o && !coalesce_o));

  // R5: allocate mode never jumps straight to no-allocate
  a_r5_one_step: assert property (@(posedge clk) disable iff (rst || !started)
    (alloc_o && !coalesce_o && !clr) |=> alloc_o);

  // R7: no-allocate holds under sequential writes and idle cycles
  a_r7_noalloc_hold: assert property (@(posedge clk) disable iff (rst || !started)
    (!alloc_o && !clr && !(wr_valid && !sh_seq)) |=> !alloc_o);

  // R4: without a write or a clear the mode does not move
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst || !started)
    (!clr && !wr_valid) |=> ($stable(alloc_o) && $stable(coalesce_o)));

  // R9: no query gives no delay answer
  a_r9_no_query_low: assert property (@(posedge clk) disable iff (rst || !started)
    !q_valid |=> !q_delay);
endmodule

bind stream_write_detector swd_checker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_size(wr_size), .q_valid(q_valid), .q_delay(q_delay),
  .alloc_o(alloc_o), .coalesce_o(coalesce_o)
);

// File: tb/sim_stream_write_detector.sv
module sim_stream_write_detector;
  localparam int AW = 12, SW = 6, BW = 8, CL = 16, NL = 40, NE = 4, DW = 3, TH = 3;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
  logic wr_valid = 1'b0, q_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [SW-1:0] wr_size = '0;
  logic [BW-1:0] wr_blk = '0, q_blk = '0;
  logic q_delay, alloc_o, coalesce_o;

  int n_chk = 0, n_bad = 0;
  int m_mode = 0, m_cnt = 0, m_next = 0;
  bit m_vld = 0;
  int m_tab [NE];

  always #4 clk = ~clk;

  stream_write_detector #(
    .ADDR_W(AW), .SIZE_W(SW), .BLK_W(BW), .COALESCE_LIMIT(CL), .NOALLOC_LIMIT(NL),
    .DELAY_ENTRIES(NE), .DELAY_W(DW), .DELAY_THRESH(TH)
  ) u0 (
    .clk(clk), .rst(rst), .clr(clr), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_blk(wr_blk), .q_valid(q_valid), .q_blk(q_blk),
    .q_delay(q_delay), .alloc_o(alloc_o), .coalesce_o(coalesce_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_mode = 0; m_cnt = 0; m_next = 0; m_vld = 0;
    for (int i = 0; i < NE; i++) m_tab[i] = 0;
  endtask

  // One cycle: present inputs at a falling edge, check at the next falling edge.
  task automatic step(input string tag, input bit c, input bit w, input int a, input int s,
                      input int b, input bit q, input int qb);
    int  qi, wi, exp_q;
    bit  sq;
    clr = c; wr_valid = w; wr_addr = AW'(a); wr_size = SW'(s); wr_blk = BW'(b);
    q_valid = q; q_blk = BW'(qb);
    @(negedge clk);
    qi = qb % NE; wi = b % NE; exp_q = 0;
    if (c) begin
      model_clear();
    end else begin
      if (q) begin
        exp_q = (m_tab[qi] != 0);
        if (m_tab[qi] > 0) m_tab[qi]--;
      end
      if (w) begin
        sq = m_vld && (a == m_next);
        m_tab[wi] = sq ? TH : 0;
        if (!sq) begin
          m_cnt = s; m_mode = 0;
        end else if (m_mode != 2) begin
          m_cnt += s;
          if (m_mode == 0 && m_cnt > CL) m_mode = 1;
          else if (m_mode == 1 && m_cnt > NL) m_mode = 2;
        end
        m_next = (a + s) % (1 << AW);
        m_vld = 1;
      end
    end
    check(tag, "alloc_o", int'(alloc_o), int'(m_mode != 2));
    check(tag, "coalesce_o", int'(coalesce_o), int'(m_mode != 0));
    check(tag, "q_delay", int'(q_delay), exp_q);
    clr = 0; wr_valid = 0; q_valid = 0;
  endtask

  task automatic wr(input string tag, input int a, input int s, input int b);
    step(tag, 0, 1, a, s, b, 0, 0);
  endtask
  task automatic qry(input string tag, input int b);
    step(tag, 0, 0, 0, 0, 0, 1, b);
  endtask
  task automatic wipe(input string tag);
    step(tag, 1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int sizes [6] = '{1, 3, 4, 8, 16, 17};
    int a;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, all slots idle
    check("R1", "alloc_o after reset", int'(alloc_o), 1);
    check("R1", "coalesce_o after reset", int'(coalesce_o), 0);
    for (int i = 0; i < NE; i++) qry("R1", i);
    // R1: first write after reset is a stream start even at address 0
    wr("R1", 0, 20, 0);

    // R4 / R5: sequential streams swept over sizes
    foreach (sizes[k]) begin
      wipe("R1");
      a = 256;
      wr("R6", a, sizes[k], a >> 4);
      for (int j = 0; j < 14; j++) begin
        a += sizes[k];
        wr("R4", a, sizes[k], a >> 4);
      end
    end

    // R7: long stream parked in no-allocate, then R6 break
    wipe("R1");
    a = 64;
    for (int j = 0; j < 12; j++) begin
      wr("R7", a, 8, a >> 4);
      a += 8;
    end
    wr("R6", a + 1, 8, 3);

    // R6 / R5: large restart lands on a limit but stays in allocate; single steps after
    wr("R6", 1000, 40, 7);
    wr("R5", 1040, 1, 7);
    wr("R5", 1041, 1, 7);
    wr("R7", 1042, 1, 7);

    // R3: off-by-one is a break; wrap through top of address space
    wipe("R1");
    wr("R3", 4000, 20, 1);
    wr("R3", 4021, 20, 1);
    wr("R3", 4064, 32, 2);
    wr("R3", 0, 32, 2);
    wr("R3", 32, 32, 2);

    // R8 / R9: slot load, drain, aliasing
    wipe("R1");
    wr("R8", 500, 4, 5);
    qry("R8", 5);
    wr("R8", 504, 4, 5);
    for (int j = 0; j < TH + 2; j++) qry("R9", 5);
    wr("R8", 508, 4, 2);
    qry("R8", 6);
    qry("R8", 10);
    wr("R8", 600, 4, 6);
    qry("R8", 2);

    // R10: write and query on the same slot in one cycle
    wr("R10", 700, 4, 3);
    step("R10", 0, 1, 704, 4, 3, 1, 3);
    qry("R10", 3);
    step("R10", 0, 1, 900, 4, 7, 1, 3);
    qry("R10", 3);

    // R11: clear beats a simultaneous write
    wipe("R1");
    a = 100;
    for (int j = 0; j < 4; j++) begin
      wr("R11", a, 16, 1);
      a += 16;
    end
    step("R11", 1, 1, a, 16, 1, 1, 1);
    wr("R11", a + 16, 16, 1);
    wr("R11", a + 32, 1, 1);
    qry("R11", 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule